// File: doc/BRIEF.md
# Redundant Clock Reference Selector

This block chooses the active timing reference for a clock unit that runs as one half of a redundant master/slave pair. Each candidate input carries a validity flag from a local monitor. The partner unit writes its own view of the inputs into a remote-valid register here. An input counts as usable only when both views agree that it is valid. As a result, both units fall back to the same external reference when one of them fails.

Two independent selection paths run side by side, each with its own priority table. The main path feeds the primary loop. The auxiliary path feeds a secondary loop and may never pick the cross-connect input that carries the partner's clock. A master/slave pin changes the policy. In slave mode, the main path locks to the cross-connect input whenever that input is usable, selection becomes revertive, phase build-out is turned off, and the loop is told to use its acquisition bandwidth. The local validity vector is brought out so that software can copy it into the partner's remote-valid register.

Every output is registered. A selection therefore reflects the inputs sampled at the previous clock edge, and it is re-evaluated on every cycle.

Top module: `rcs_ref_selector`

## Requirements
- R1: An input is usable only when its `loc_valid` bit and the same bit of the remote-valid register are both 1. If either bit is 0, the input is never selected.
- R2: The 16-bit remote-valid register resets to all ones. `rv_wr_lo` loads `rv_wr_data` into bits 7:0 and `rv_wr_hi` loads it into bits 15:8. Bit i masks input i, and the new value takes effect on the selection at the following edge.
- R3: Each path chooses the usable input with the lowest nonzero 4-bit priority. Priority 0 disables an input, and a tie goes to the lower input index.
- R4: When the effective mode is non-revertive, a path keeps its current input while that input stays usable with a nonzero priority. This holds even when a better input appears.
- R5: When the effective mode is revertive, a path moves to the best usable input on the cycle after that input becomes the best one.
- R6: With `ms_pin` = 0 (slave), the main path selects input 11 whenever input 11 is usable, whatever its programmed priority.
- R7: With `ms_pin` = 1 (master), `pbo_en`, `revert_en` and `bw_acq` follow `cfg_pbo_en`, `cfg_revertive` and `cfg_bw_acq`. With `ms_pin` = 0, they are forced to 0, 1 and 1.
- R8: The auxiliary path uses its own priority table (`aux_prio`) and never selects input 11.
- R9: A path with no usable input that has a nonzero priority drives `*_sel_vld` = 0 and `*_sel_idx` = 0. The auxiliary path has no holdover.
- R10: `*_sel_chg` is high for exactly the cycle in which that path's `{vld, idx}` differs from its value on the cycle before.
- R11: `sts_local_valid` shows `loc_valid`, zero-extended to 16 bits and registered.
- R12: During and right after reset, both selections are invalid with index 0, the change pulses are 0, the flags hold the slave values (0, 1, 1), and `sts_local_valid` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| ms_pin | input | 1 | 1 = master, 0 = slave |
| loc_valid | input | 14 | Local monitor validity, one bit per input |
| rv_wr_lo | input | 1 | Write strobe for remote-valid bits 7:0 |
| rv_wr_hi | input | 1 | Write strobe for remote-valid bits 15:8 |
| rv_wr_data | input | 8 | Data for the remote-valid half being written |
| main_prio | input | 56 | Main-path priorities, input i at bits 4i+3:4i |
| aux_prio | input | 56 | Auxiliary-path priorities, same layout |
| cfg_pbo_en | input | 1 | Phase build-out enable used in master mode |
| cfg_revertive | input | 1 | Revertive selection used in master mode |
| cfg_bw_acq | input | 1 | Acquisition bandwidth request used in master mode |
| main_sel_idx | output | 4 | Main-path selected input |
| main_sel_vld | output | 1 | Main-path selection valid |
| main_sel_chg | output | 1 | Main-path selection change pulse |
| aux_sel_idx | output | 4 | Auxiliary-path selected input |
| aux_sel_vld | output | 1 | Auxiliary-path selection valid |
| aux_sel_chg | output | 1 | Auxiliary-path selection change pulse |
| pbo_en | output | 1 | Phase build-out enable to the loop |
| revert_en | output | 1 | Effective revertive mode |
| bw_acq | output | 1 | Acquisition bandwidth select to the loop |
| sts_local_valid | output | 16 | Registered local validity for copying to the partner |

## Verification
The assertions assume that `ms_pin`, `loc_valid`, the priority tables and the write strobes change only between clock edges and stay stable across each edge. They also assume that a write strobe is never present during reset. The stimulus drives every input on the falling edge and raises the strobes only after reset has been released. The strobes may be combined freely with any change of validity or mode, because the assertions compare each selection with the usable set of the previous cycle rather than with any assumed ordering of events.

// File: rtl/rcs_pkg.sv
package rcs_pkg;
  parameter int unsigned RCS_IDX_W = 4;

  typedef struct packed {
    logic                 vld;
    logic [RCS_IDX_W-1:0] idx;
  } rcs_sel_t;
endpackage

// File: rtl/rcs_remote_reg.sv
module rcs_remote_reg #(
  parameter int unsigned REG_W  = 16,
  parameter int unsigned HALF_W = 8
) (
  input  logic                        clk,
  input  logic                        rst,
  input  logic [REG_W/HALF_W-1:0]     wr_half,
  input  logic [HALF_W-1:0]           wr_data,
  output logic [REG_W-1:0]            mask
);
  localparam int unsigned N_HALF = REG_W / HALF_W;

  for (genvar h = 0; h < N_HALF; h++) begin : g_half
    always_ff @(posedge clk) begin
      if (rst) begin
        mask[h*HALF_W +: HALF_W] <= '1;
      end else if (wr_half[h]) begin
        mask[h*HALF_W +: HALF_W] <= wr_data;
      end
    end
  end

  AST_MASK_HOLD: assert property (@(posedge clk) disable iff (rst)
    (wr_half == '0) |=> $stable(mask));  // R2
endmodule

// File: rtl/rcs_path.sv
module rcs_path #(
  parameter int unsigned N_IN     = 14,
  parameter int unsigned PRIO_W   = 4,
  parameter int unsigned IDX_W    = rcs_pkg::RCS_IDX_W,
  parameter int unsigned XC_IDX   = 11,
  parameter bit          EXCL_XC  = 1'b0,
  parameter bit          HONOR_XC = 1'b0
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic [N_IN-1:0]          usable,
  input  logic [N_IN*PRIO_W-1:0]   prio_flat,
  input  logic                     force_xc,
  input  logic                     revertive,
  output logic [IDX_W-1:0]         sel_idx,
  output logic                     sel_vld,
  output logic                     sel_chg
);
  localparam logic [N_IN-1:0]  XC_BIT   = N_IN'(1) << XC_IDX;
  localparam logic [IDX_W-1:0] XC_IDX_V = IDX_W'(XC_IDX);

  logic [PRIO_W-1:0] prio [N_IN];
  logic [N_IN-1:0]   usable_eff;
  logic [N_IN-1:0]   sel_oh;

  for (genvar i = 0; i < N_IN; i++) begin : g_prio
    assign prio[i] = prio_flat[i*PRIO_W +: PRIO_W];
  end

  if (EXCL_XC) begin : g_excl
    assign usable_eff = usable & ~XC_BIT;
  end else begin : g_all
    assign usable_eff = usable;
  end

  assign sel_oh = N_IN'(1) << sel_idx;

  // best candidate: lowest nonzero priority, ties to lower index
  logic              best_found;
  logic [IDX_W-1:0]  best_idx;
  logic [PRIO_W-1:0] best_p;

  always_comb begin
    best_found = 1'b0;
    best_idx   = '0;
    best_p     = '1;
    for (int i = 0; i < N_IN; i++) begin
      if (usable_eff[i] && (prio[i] != '0) && (!best_found || (prio[i] < best_p))) begin
        best_found = 1'b1;
        best_p     = prio[i];
        best_idx   = IDX_W'(i);
      end
    end
  end

  logic              cur_ok;
  logic              xc_take;
  logic              nxt_vld;
  logic [IDX_W-1:0]  nxt_idx;

  assign cur_ok = sel_vld && |(usable_eff & sel_oh) && (prio[sel_idx] != '0);

  if (HONOR_XC) begin : g_force
    assign xc_take = force_xc && usable_eff[XC_IDX];
  end else begin : g_noforce
    assign xc_take = 1'b0;
  end

  always_comb begin
    if (xc_take) begin
      nxt_vld = 1'b1;
      nxt_idx = XC_IDX_V;
    end else if (!revertive && cur_ok) begin
      nxt_vld = 1'b1;
      nxt_idx = sel_idx;
    end else begin
      nxt_vld = best_found;
      nxt_idx = best_idx;
    end
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      sel_vld <= 1'b0;
      sel_idx <= '0;
      sel_chg <= 1'b0;
    end else begin
      sel_vld <= nxt_vld;
      sel_idx <= nxt_idx;
      sel_chg <= (nxt_vld != sel_vld) || (nxt_idx != sel_idx);
    end
  end

  AST_SEL_USABLE: assert property (@(posedge clk) disable iff (rst)
    (sel_vld && !$past(rst)) |-> |($past(usable_eff) & sel_oh));  // R1
  AST_NONE_INVALID: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && ($past(usable_eff) == '0)) |-> (!sel_vld && sel_idx == '0));  // R9
  AST_CHG_TRACKS: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst)) |-> (sel_chg == (({sel_vld, sel_idx}) != $past({sel_vld, sel_idx}))));  // R10
  AST_KEEP_NONREV: assert property (@(posedge clk) disable iff (rst)
    ($past(!revertive && !xc_take && cur_ok) && !$past(rst)) |-> $stable({sel_vld, sel_idx}));  // R4

  if (EXCL_XC) begin : g_ast_excl
    AST_NO_XCONN: assert property (@(posedge clk) disable iff (rst)
      sel_vld |-> (sel_idx != XC_IDX_V));  // R8
  end
endmodule

// File: rtl/rcs_ref_selector.sv
module rcs_ref_selector #(
  parameter int unsigned N_IN   = 14,
  parameter int unsigned PRIO_W = 4,
  parameter int unsigned VREG_W = 16,
  parameter int unsigned HALF_W = 8,
  parameter int unsigned XC_IDX = 11,
  parameter int unsigned IDX_W  = rcs_pkg::RCS_IDX_W
) (
  input  logic                     clk,
  input  logic                     rst,
  input  logic                     ms_pin,
  input  logic [N_IN-1:0]          loc_valid,
  input  logic                     rv_wr_lo,
  input  logic                     rv_wr_hi,
  input  logic [HALF_W-1:0]        rv_wr_data,
  input  logic [N_IN*PRIO_W-1:0]   main_prio,
  input  logic [N_IN*PRIO_W-1:0]   aux_prio,
  input  logic                     cfg_pbo_en,
  input  logic                     cfg_revertive,
  input  logic                     cfg_bw_acq,
  output logic [IDX_W-1:0]         main_sel_idx,
  output logic                     main_sel_vld,
  output logic                     main_sel_chg,
  output logic [IDX_W-1:0]         aux_sel_idx,
  output logic                     aux_sel_vld,
  output logic                     aux_sel_chg,
  output logic                     pbo_en,
  output logic                     revert_en,
  output logic                     bw_acq,
  output logic [VREG_W-1:0]        sts_local_valid
);
  import rcs_pkg::*;

  logic [VREG_W-1:0] rmt_mask;
  logic [N_IN-1:0]   usable;
  logic              slave;
  logic              rev_eff;

  rcs_remote_reg #(.REG_W(VREG_W), .HALF_W(HALF_W)) i_rmt (
    .clk     (clk),
    .rst     (rst),
    .wr_half ({rv_wr_hi, rv_wr_lo}),
    .wr_data (rv_wr_data),
    .mask    (rmt_mask)
  );

  assign usable  = loc_valid & rmt_mask[N_IN-1:0];
  assign slave   = !ms_pin;
  assign rev_eff = slave ? 1'b1 : cfg_revertive;

  rcs_path #(
    .N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .XC_IDX(XC_IDX),
    .EXCL_XC(1'b0), .HONOR_XC(1'b1)
  ) i_main (
    .clk       (clk),
    .rst       (rst),
    .usable    (usable),
    .prio_flat (main_prio),
    .force_xc  (slave),
    .revertive (rev_eff),
    .sel_idx   (main_sel_idx),
    .sel_vld   (main_sel_vld),
    .sel_chg   (main_sel_chg)
  );

  rcs_path #(
    .N_IN(N_IN), .PRIO_W(PRIO_W), .IDX_W(IDX_W), .XC_IDX(XC_IDX),
    .EXCL_XC(1'b1), .HONOR_XC(1'b0)
  ) i_aux (
    .clk       (clk),
    .rst       (rst),
    .usable    (usable),
    .prio_flat (aux_prio),
    .force_xc  (1'b0),
    .revertive (rev_eff),
    .sel_idx   (aux_sel_idx),
    .sel_vld   (aux_sel_vld),
    .sel_chg   (aux_sel_chg)
  );

  always_ff @(posedge clk) begin
    if (rst) begin
      pbo_en          <= 1'b0;
      revert_en       <= 1'b1;
      bw_acq          <= 1'b1;
      sts_local_valid <= '0;
    end else begin
      pbo_en          <= slave ? 1'b0 : cfg_pbo_en;
      revert_en       <= rev_eff;
      bw_acq          <= slave ? 1'b1 : cfg_bw_acq;
      sts_local_valid <= VREG_W'(loc_valid);
    end
  end

  AST_SLAVE_FLAGS: assert property (@(posedge clk) disable iff (rst)
    !$past(ms_pin) |-> (!pbo_en && revert_en && bw_acq));  // R7
  AST_SLAVE_XCONN: assert property (@(posedge clk) disable iff (rst)
    (!$past(rst) && $past(!ms_pin && usable[XC_IDX])) |->
      (main_sel_vld && main_sel_idx == IDX_W'(XC_IDX)));  // R6
  AST_STS_FOLLOW: assert property (@(posedge clk) disable iff (rst)
    !$past(rst) |-> (sts_local_valid == VREG_W'($past(loc_valid))));  // R11
endmodule

// File: tb/test_rcs_ref_selector.sv
module test_rcs_ref_selector;
  localparam int N = 14;
  localparam int XC = 11;

  logic clk = 1'b0;
  logic rst = 1'b1;
  logic ms_pin = 1'b1;
  logic [N-1:0] loc_valid = '0;
  logic rv_wr_lo = 1'b0, rv_wr_hi = 1'b0;
  logic [7:0] rv_wr_data = '0;
  logic [N*4-1:0] main_prio = '0, aux_prio = '0;
  logic cfg_pbo_en = 1'b0, cfg_revertive = 1'b1, cfg_bw_acq = 1'b0;
  logic [3:0] main_sel_idx, aux_sel_idx;
  logic main_sel_vld, main_sel_chg, aux_sel_vld, aux_sel_chg;
  logic pbo_en, revert_en, bw_acq;
  logic [15:0] sts_local_valid;

  always #5 clk = ~clk;

  rcs_ref_selector i_rcs_ref_selector (
    .clk(clk), .rst(rst), .ms_pin(ms_pin), .loc_valid(loc_valid),
    .rv_wr_lo(rv_wr_lo), .rv_wr_hi(rv_wr_hi), .rv_wr_data(rv_wr_data),
    .main_prio(main_prio), .aux_prio(aux_prio),
    .cfg_pbo_en(cfg_pbo_en), .cfg_revertive(cfg_revertive), .cfg_bw_acq(cfg_bw_acq),
    .main_sel_idx(main_sel_idx), .main_sel_vld(main_sel_vld), .main_sel_chg(main_sel_chg),
    .aux_sel_idx(aux_sel_idx), .aux_sel_vld(aux_sel_vld), .aux_sel_chg(aux_sel_chg),
    .pbo_en(pbo_en), .revert_en(revert_en), .bw_acq(bw_acq),
    .sts_local_valid(sts_local_valid)
  );

  int checks = 0;
  int failures = 0;
  bit done = 1'b0;
  string phase = "R12";

  // behavioural reference model
  int unsigned m_rmt;
  int m_main_idx, m_aux_idx;
  bit m_main_vld, m_aux_vld, m_main_chg, m_aux_chg;
  bit m_pbo, m_rev, m_bw;
  int unsigned m_sts;

  function automatic int prio_of(logic [N*4-1:0] tbl, int i);
    return int'(tbl[i*4 +: 4]);
  endfunction

  task automatic pick(input int unsigned use_mask, input logic [N*4-1:0] tbl,
                      input bit rev, inout int idx, inout bit vld);
    int bi = -1;
    int bp = 99;
    if (!rev && vld && use_mask[idx] && prio_of(tbl, idx) != 0) return;
    for (int i = 0; i < N; i++) begin
      if (use_mask[i] && prio_of(tbl, i) != 0 && prio_of(tbl, i) < bp) begin
        bp = prio_of(tbl, i);
        bi = i;
      end
    end
    vld = (bi >= 0);
    idx = (bi >= 0) ? bi : 0;
  endtask

  always @(posedge clk) begin
    if (rst) begin
      m_rmt = 32'hFFFF;
      m_main_idx = 0; m_main_vld = 0; m_main_chg = 0;
      m_aux_idx = 0; m_aux_vld = 0; m_aux_chg = 0;
      m_pbo = 0; m_rev = 1; m_bw = 1; m_sts = 0;
    end else begin
      int unsigned use_m;
      int pi, ai;
      bit pv, av, slv, rv;
      use_m = int'(loc_valid) & m_rmt & 32'h3FFF;
      slv = !ms_pin;
      rv = slv ? 1'b1 : cfg_revertive;
      pi = m_main_idx; pv = m_main_vld;
      if (slv && use_m[XC]) begin pi = XC; pv = 1; end
      else pick(use_m, main_prio, rv, pi, pv);
      ai = m_aux_idx; av = m_aux_vld;
      pick(use_m & ~(32'd1 << XC), aux_prio, rv, ai, av);
      m_main_chg = (pi != m_main_idx) || (pv != m_main_vld);
      m_aux_chg = (ai != m_aux_idx) || (av != m_aux_vld);
      m_main_idx = pi; m_main_vld = pv; m_aux_idx = ai; m_aux_vld = av;
      m_pbo = slv ? 1'b0 : cfg_pbo_en;
      m_rev = rv;
      m_bw = slv ? 1'b1 : cfg_bw_acq;
      m_sts = int'(loc_valid);
      if (rv_wr_lo) m_rmt = (m_rmt & 32'hFF00) | int'(rv_wr_data);
      if (rv_wr_hi) m_rmt = (m_rmt & 32'h00FF) | (int'(rv_wr_data) << 8);
    end
  end

  task automatic chk(input bit ok, input string tag, input int act, input int exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s: actual=%0d expected=%0d at %0t", tag, act, exp, $time);
    end
  endtask

  // compare with the model on every falling edge
  always @(negedge clk) begin
    if (!done) begin
      chk({main_sel_vld, main_sel_idx} == {m_main_vld, 4'(m_main_idx)},
          {phase, " main sel R3"}, {main_sel_vld, main_sel_idx}, {m_main_vld, 4'(m_main_idx)});
      chk({aux_sel_vld, aux_sel_idx} == {m_aux_vld, 4'(m_aux_idx)},
          {phase, " aux sel R8"}, {aux_sel_vld, aux_sel_idx}, {m_aux_vld, 4'(m_aux_idx)});
      chk({main_sel_chg, aux_sel_chg} == {m_main_chg, m_aux_chg},
          {phase, " chg R10"}, {main_sel_chg, aux_sel_chg}, {m_main_chg, m_aux_chg});
      chk({pbo_en, revert_en, bw_acq} == {m_pbo, m_rev, m_bw},
          {phase, " flags R7"}, {pbo_en, revert_en, bw_acq}, {m_pbo, m_rev, m_bw});
      chk(sts_local_valid == 16'(m_sts), {phase, " sts R11"}, sts_local_valid, m_sts);
    end
  end

  task automatic step(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic set_p(inout logic [N*4-1:0] tbl, input int i, input int p);
    tbl[i*4 +: 4] = 4'(p);
  endtask

  task automatic wr_rmt(input bit hi, input logic [7:0] d);
    rv_wr_data = d;
    if (hi) rv_wr_hi = 1'b1; else rv_wr_lo = 1'b1;
    step(1);
    rv_wr_lo = 1'b0; rv_wr_hi = 1'b0;
  endtask

  task automatic expect_main(input string tag, input bit v, input int idx);
    chk(main_sel_vld == v && (!v || main_sel_idx == 4'(idx)), tag,
        {main_sel_vld, main_sel_idx}, {v, 4'(idx)});
  endtask

  initial begin
    step(3);
    // R12: reset values
    chk(!main_sel_vld && main_sel_idx == 0 && !aux_sel_vld && !main_sel_chg,
        "R12 reset sel", {main_sel_vld, main_sel_idx}, 0);
    chk({pbo_en, revert_en, bw_acq} == 3'b011 && sts_local_valid == 0,
        "R12 reset flags", {pbo_en, revert_en, bw_acq}, 3);
    for (int i = 0; i < N; i++) begin set_p(main_prio, i, 9); set_p(aux_prio, i, 8); end
    set_p(main_prio, 2, 0); set_p(main_prio, 5, 3); set_p(main_prio, 7, 3);
    set_p(aux_prio, XC, 1); set_p(aux_prio, 3, 2);
    loc_valid = '1;
    rst = 1'b0;
    phase = "R3";
    step(3);
    expect_main("R3 lowest prio tie low index", 1, 5);
    phase = "R8";
    chk(aux_sel_vld && aux_sel_idx == 3, "R8 aux skips input 11", aux_sel_idx, 3);
    phase = "R1";
    loc_valid[5] = 1'b0; step(2);
    expect_main("R1 local invalid", 1, 7);
    loc_valid[5] = 1'b1; step(2);
    expect_main("R1 restore", 1, 5);
    phase = "R2";
    wr_rmt(1'b0, 8'hDF); step(1);
    expect_main("R2 remote lo masks input 5", 1, 7);
    phase = "R4";
    cfg_revertive = 1'b0; step(2);
    wr_rmt(1'b0, 8'hFF); step(3);
    expect_main("R4 non-revertive holds 7", 1, 7);
    loc_valid[7] = 1'b0; step(2);
    expect_main("R4 loss switches to 5", 1, 5);
    phase = "R5";
    cfg_revertive = 1'b1;
    loc_valid[7] = 1'b1; set_p(main_prio, 7, 1); step(2);
    expect_main("R5 revertive moves to 7", 1, 7);
    phase = "R7";
    cfg_pbo_en = 1'b1; cfg_bw_acq = 1'b0; cfg_revertive = 1'b0; step(2);
    chk({pbo_en, revert_en, bw_acq} == 3'b100, "R7 master passes cfg", {pbo_en, revert_en, bw_acq}, 4);
    phase = "R6";
    set_p(main_prio, XC, 0);
    ms_pin = 1'b0; step(2);
    expect_main("R6 slave forces input 11", 1, XC);
    chk({pbo_en, revert_en, bw_acq} == 3'b011, "R7 slave forced flags", {pbo_en, revert_en, bw_acq}, 3);
    wr_rmt(1'b1, 8'hF7); step(1);
    expect_main("R6 remote masks 11", 1, 7);
    wr_rmt(1'b1, 8'hFF); step(1);
    expect_main("R6 revert to 11", 1, XC);
    phase = "R9";
    loc_valid = '0; step(2);
    expect_main("R9 none usable", 0, 0);
    chk(!aux_sel_vld && aux_sel_idx == 0, "R9 aux no holdover", aux_sel_idx, 0);
    loc_valid = 14'(1 << XC); step(2);
    chk(!aux_sel_vld, "R9 aux only 11 usable", aux_sel_vld, 0);
    ms_pin = 1'b1; step(2);
    phase = "R10";
    loc_valid = '1; step(1);
    chk(main_sel_chg == 1'b1, "R10 pulse on change", main_sel_chg, 1);
    step(1);
    chk(main_sel_chg == 1'b0, "R10 pulse one cycle", main_sel_chg, 0);
    phase = "RND";
    for (int c = 0; c < 3000; c++) begin
      loc_valid = 14'($urandom) | 14'($urandom);
      if ($urandom_range(7) == 0) ms_pin = $urandom_range(1);
      if ($urandom_range(5) == 0) cfg_revertive = $urandom_range(1);
      cfg_pbo_en = $urandom_range(1); cfg_bw_acq = $urandom_range(1);
      if ($urandom_range(9) == 0) set_p(main_prio, $urandom_range(N - 1), $urandom_range(15));
      if ($urandom_range(9) == 0) set_p(aux_prio, $urandom_range(N - 1), $urandom_range(15));
      rv_wr_lo = ($urandom_range(15) == 0);
      rv_wr_hi = ($urandom_range(15) == 0);
      rv_wr_data = 8'($urandom) | 8'($urandom);
      step(1);
    end
    rv_wr_lo = 1'b0; rv_wr_hi = 1'b0;
    step(2);
    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    #1_000_000;
    if (!done) begin
      done = 1'b1;
      checks++; failures++;
      $display("FAIL watchdog: actual=timeout expected=completion");
      $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
      $finish;
    end
  end
endmodule